// File: doc/BRIEF.md
# Step/Direction Microstep Translator

This block converts a train of step pulses and a direction level into current setpoints for the two windings of a two-phase bipolar stepper motor. It keeps an electrical angle as a 6-bit index that covers one full electrical cycle in 64 positions of 5.625° each. On every accepted step the index moves forward or backward by a stride that depends on the selected resolution. Phase 1 follows the cosine of that angle and phase 2 follows its sine, so phase 2 lags phase 1 by a quarter cycle. Both are read from a 17-point quarter-wave table.

Each phase is reported as an 8-bit magnitude code and a separate sign bit, ready for a current-regulation DAC. A per-phase flag reports whether the last step lowered that phase's magnitude, so that a downstream regulator can pick its decay behaviour. The step input is asynchronous and is brought into the system clock domain before its rising edges are detected. Reset and sleep both park the index at the 45° home position. A drive-enable input blanks the setpoints without stopping the translation.

Top module: `stepper_xlat`

## Requirements
- R1: While `rst` is high, and from then until the first accepted step, the index sits at home (45°, index 8). Both magnitudes read 180, both sign bits read 0 and both decreasing flags read 0.
- R2: The resolution is sampled on each accepted step, with `mode_i` bit 0 as the first select line. 3'b000 moves 16 positions (full step), 3'b001 moves 8 (half), 3'b010 moves 4 (quarter) and 3'b011 moves 2 (eighth). 3'b111 and every other code move 1 position (sixteenth).
- R3: `dir_i` is sampled only on an accepted step: 1 moves the index up and 0 moves it down. Changing `dir_i` or `mode_i` between steps leaves every output unchanged.
- R4: The magnitude codes for quarter-wave points k = 0..16 (sin(k·5.625°) scaled so 255 is full current) are 0, 25, 50, 74, 98, 120, 142, 162, 180, 197, 212, 225, 236, 244, 250, 254, 255.
- R5: Phase 1 equals cos(index·5.625°) and phase 2 equals sin(index·5.625°). A sign bit is 1 only when its value is strictly negative, so a zero magnitude always carries sign 0.
- R6: A rising edge on `step_i` takes effect on the third rising clock edge after it is set up. A level held high causes no further step.
- R7: While `sleep_i` is high, step edges are ignored and the index is held at home. After `sleep_i` falls the block resumes from home.
- R8: While `enable_i` is low, both magnitudes and both sign bits read 0. Accepted steps still move the index, and raising `enable_i` shows the advanced position.
- R9: On each accepted step, each phase's decreasing flag becomes 1 if the new magnitude is lower than the previous one and 0 otherwise. The flag holds between steps.
- R10: The index wraps modulo 64, so 64 sixteenth steps in one direction return to home.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | Asynchronous step request, rising edge active |
| dir_i | input | 1 | Rotation direction, sampled on accepted steps |
| mode_i | input | 3 | Resolution select |
| sleep_i | input | 1 | Active-high sleep, parks the index at home |
| enable_i | input | 1 | Active-high drive enable for the setpoints |
| ph1_mag_o | output | 8 | Phase 1 magnitude code |
| ph1_neg_o | output | 1 | Phase 1 sign, 1 = negative |
| ph1_dec_o | output | 1 | Phase 1 magnitude fell on the last step |
| ph2_mag_o | output | 8 | Phase 2 magnitude code |
| ph2_neg_o | output | 1 | Phase 2 sign, 1 = negative |
| ph2_dec_o | output | 1 | Phase 2 magnitude fell on the last step |

## Verification
The wrap of the index across zero is the hardest case to reach. Every run starts at 45°, so it takes a long chain of same-direction steps, or a reversal past index 0, to cross it. The bench drives a full 64-step sixteenth sweep and checks every position, its signs and its decreasing flags on the way. It also reverses direction from home across zero. It also changes direction and resolution between pulses while keeping the step input still, to show that those levels only matter at the sampled edge.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int IDX_W    = 6;
    localparam int MAG_W    = 8;
    localparam int QTR      = 16;
    localparam int QK_W     = $clog2(QTR + 1);
    localparam logic [IDX_W-1:0] HOME_IDX = IDX_W'(QTR / 2);

    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [MAG_W-1:0] mag_t;

    typedef enum logic [2:0] {
        RES_FULL      = 3'b000,
        RES_HALF      = 3'b001,
        RES_QUARTER   = 3'b010,
        RES_EIGHTH    = 3'b011,
        RES_SIXTEENTH = 3'b111
    } res_t;

    typedef struct packed {
        logic neg;
        mag_t mag;
    } phase_pt_t;

    function automatic idx_t stride_of(input logic [2:0] code);
        case (code)
            RES_FULL:    return idx_t'(16);
            RES_HALF:    return idx_t'(8);
            RES_QUARTER: return idx_t'(4);
            RES_EIGHTH:  return idx_t'(2);
            default:     return idx_t'(1);
        endcase
    endfunction

    function automatic mag_t qwave(input logic [QK_W-1:0] k);
        case (k)
            5'd0:  return 8'd0;
            5'd1:  return 8'd25;
            5'd2:  return 8'd50;
            5'd3:  return 8'd74;
            5'd4:  return 8'd98;
            5'd5:  return 8'd120;
            5'd6:  return 8'd142;
            5'd7:  return 8'd162;
            5'd8:  return 8'd180;
            5'd9:  return 8'd197;
            5'd10: return 8'd212;
            5'd11: return 8'd225;
            5'd12: return 8'd236;
            5'd13: return 8'd244;
            5'd14: return 8'd250;
            5'd15: return 8'd254;
            default: return 8'd255;
        endcase
    endfunction

    // cosine of angle j*5.625 deg: quadrant picks mirror and sign
    function automatic phase_pt_t cos_point(input idx_t j);
        phase_pt_t p;
        logic [1:0] quad;
        logic [QK_W-1:0] off;
        logic [QK_W-1:0] k;
        quad = j[IDX_W-1 -: 2];
        off  = QK_W'(j[IDX_W-3:0]);
        k    = quad[0] ? off : QK_W'(QTR) - off;
        p.mag = qwave(k);
        p.neg = (quad == 2'd1 || quad == 2'd2) && (p.mag != '0);
        return p;
    endfunction

endpackage

// File: rtl/xlat_sync.sv
module xlat_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-1:0], async_i};
    end

    assign rise_o = chain[STAGES-1] & ~chain[STAGES];

    p_single_rise_r6: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);
endmodule

// File: rtl/xlat_index.sv
module xlat_index
    import xlat_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hold_i,
    input  logic       step_en_i,
    input  logic       dir_i,
    input  logic [2:0] mode_i,
    output idx_t       idx_o,
    output idx_t       idx_next_o
);
    idx_t idx_q;
    idx_t stride;

    always_comb begin
        stride     = stride_of(mode_i);
        idx_next_o = dir_i ? idx_q + stride : idx_q - stride;
    end

    always_ff @(posedge clk) begin
        if (rst || hold_i)  idx_q <= HOME_IDX;
        else if (step_en_i) idx_q <= idx_next_o;
    end

    assign idx_o = idx_q;

    p_home_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> idx_q == HOME_IDX);
    p_sleep_home_r7: assert property (@(posedge clk) disable iff (rst)
        hold_i |=> idx_q == HOME_IDX);
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!step_en_i && !hold_i) |=> $stable(idx_q));
endmodule

// File: rtl/xlat_phase.sv
module xlat_phase
    import xlat_pkg::*;
#(
    parameter int LAG = 0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      hold_i,
    input  logic      step_en_i,
    input  idx_t      idx_i,
    input  idx_t      idx_next_i,
    output phase_pt_t pt_o,
    output logic      dec_o
);
    localparam idx_t SHIFT = idx_t'(LAG);

    phase_pt_t pt_next;
    logic      dec_q;

    always_comb begin
        pt_o    = cos_point(idx_i - SHIFT);
        pt_next = cos_point(idx_next_i - SHIFT);
    end

    always_ff @(posedge clk) begin
        if (rst || hold_i)  dec_q <= 1'b0;
        else if (step_en_i) dec_q <= pt_next.mag < pt_o.mag;
    end

    assign dec_o = dec_q;

    p_dec_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!step_en_i && !hold_i) |=> $stable(dec_q));
    p_mag_needs_step_r3: assert property (@(posedge clk) disable iff (rst)
        (!step_en_i && !hold_i) |=> $stable(pt_o.mag));
endmodule

// File: rtl/stepper_xlat.sv
module stepper_xlat
    import xlat_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       step_i,
    input  logic       dir_i,
    input  logic [2:0] mode_i,
    input  logic       sleep_i,
    input  logic       enable_i,
    output logic [7:0] ph1_mag_o,
    output logic       ph1_neg_o,
    output logic       ph1_dec_o,
    output logic [7:0] ph2_mag_o,
    output logic       ph2_neg_o,
    output logic       ph2_dec_o
);
    localparam int NPH = 2;

    logic      step_rise;
    logic      step_go;
    idx_t      idx_cur;
    idx_t      idx_nxt;
    phase_pt_t pt  [NPH];
    logic      dec [NPH];

    xlat_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (step_i),
        .rise_o  (step_rise)
    );

    assign step_go = step_rise & ~sleep_i;

    xlat_index u_index (
        .clk        (clk),
        .rst        (rst),
        .hold_i     (sleep_i),
        .step_en_i  (step_go),
        .dir_i      (dir_i),
        .mode_i     (mode_i),
        .idx_o      (idx_cur),
        .idx_next_o (idx_nxt)
    );

    for (genvar g = 0; g < NPH; g++) begin : g_phase
        xlat_phase #(.LAG(g * QTR)) u_phase (
            .clk        (clk),
            .rst        (rst),
            .hold_i     (sleep_i),
            .step_en_i  (step_go),
            .idx_i      (idx_cur),
            .idx_next_i (idx_nxt),
            .pt_o       (pt[g]),
            .dec_o      (dec[g])
        );
    end

    always_comb begin
        ph1_mag_o = enable_i ? pt[0].mag : '0;
        ph1_neg_o = enable_i & pt[0].neg;
        ph2_mag_o = enable_i ? pt[1].mag : '0;
        ph2_neg_o = enable_i & pt[1].neg;
        ph1_dec_o = dec[0];
        ph2_dec_o = dec[1];
    end
endmodule

// File: tb/test_stepper_xlat.sv
module test_stepper_xlat;
    localparam time CLK_P = 20ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       step_i = 1'b0;
    logic       dir_i = 1'b1;
    logic [2:0] mode_i = 3'b111;
    logic       sleep_i = 1'b0;
    logic       enable_i = 1'b1;
    logic [7:0] ph1_mag_o, ph2_mag_o;
    logic       ph1_neg_o, ph1_dec_o, ph2_neg_o, ph2_dec_o;

    int n_chk = 0;
    int n_err = 0;
    int e_idx = 8;
    int e_dec1 = 0;
    int e_dec2 = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    stepper_xlat i_stepper_xlat (
        .clk(clk), .rst(rst), .step_i(step_i), .dir_i(dir_i), .mode_i(mode_i),
        .sleep_i(sleep_i), .enable_i(enable_i),
        .ph1_mag_o(ph1_mag_o), .ph1_neg_o(ph1_neg_o), .ph1_dec_o(ph1_dec_o),
        .ph2_mag_o(ph2_mag_o), .ph2_neg_o(ph2_neg_o), .ph2_dec_o(ph2_dec_o)
    );

    function automatic int tbl(int k);
        case (k)
            0: return 0;    1: return 25;   2: return 50;   3: return 74;
            4: return 98;   5: return 120;  6: return 142;  7: return 162;
            8: return 180;  9: return 197;  10: return 212; 11: return 225;
            12: return 236; 13: return 244; 14: return 250; 15: return 254;
            default: return 255;
        endcase
    endfunction

    // cosine model: distance from the nearest zero crossing of the half cycle
    function automatic int cmag(int a);
        int d = 16 - (a % 32);
        if (d < 0) d = -d;
        return tbl(d);
    endfunction
    function automatic int cneg(int a);
        return (a > 16 && a < 48) ? 1 : 0;
    endfunction
    function automatic int sang(int a);
        return (a + 48) % 64;
    endfunction
    function automatic int stride_model(logic [2:0] m);
        case (m)
            3'b000: return 16;
            3'b001: return 8;
            3'b010: return 4;
            3'b011: return 2;
            default: return 1;
        endcase
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_pos(string req);
        chk(req, "ph1 mag", ph1_mag_o, cmag(e_idx));
        chk(req, "ph1 neg", ph1_neg_o, cneg(e_idx));
        chk(req, "ph2 mag", ph2_mag_o, cmag(sang(e_idx)));
        chk(req, "ph2 neg", ph2_neg_o, cneg(sang(e_idx)));
    endtask

    task automatic check_dec(string req);
        chk(req, "ph1 dec", ph1_dec_o, e_dec1);
        chk(req, "ph2 dec", ph2_dec_o, e_dec2);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; step_i = 1'b0; sleep_i = 1'b0; enable_i = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        e_idx = 8; e_dec1 = 0; e_dec2 = 0;
        @(negedge clk);
    endtask

    // pulse with model update; result is visible after three clock edges
    task automatic pulse(bit model);
        int o1, o2;
        @(negedge clk);
        step_i = 1'b1;
        repeat (3) @(negedge clk);
        if (model) begin
            o1 = cmag(e_idx);
            o2 = cmag(sang(e_idx));
            e_idx = (e_idx + (dir_i ? stride_model(mode_i) : 64 - stride_model(mode_i))) % 64;
            e_dec1 = (cmag(e_idx) < o1) ? 1 : 0;
            e_dec2 = (cmag(sang(e_idx)) < o2) ? 1 : 0;
        end
        repeat (2) @(negedge clk);
        step_i = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check_pos("R1");
        chk("R1", "home ph1 mag", ph1_mag_o, 180);
        chk("R1", "home ph2 mag", ph2_mag_o, 180);
        check_dec("R1");
    endtask

    task automatic t_sweep();
        do_reset();
        mode_i = 3'b111; dir_i = 1'b1;
        for (int i = 0; i < 64; i++) begin
            pulse(1);
            check_pos("R4 R5");
            check_dec("R9");
        end
        chk("R10", "wrap ph1 mag", ph1_mag_o, 180);
        chk("R10", "wrap ph2 mag", ph2_mag_o, 180);
        chk("R10", "wrap ph1 neg", ph1_neg_o, 0);
    endtask

    task automatic t_modes();
        for (int m = 0; m < 8; m++) begin
            do_reset();
            mode_i = 3'(m); dir_i = 1'b1;
            for (int s = 0; s < 3; s++) begin
                pulse(1);
                check_pos("R2");
                check_dec("R9");
            end
        end
        do_reset();
        mode_i = 3'b000;
        for (int s = 0; s < 4; s++) begin
            pulse(1);
            chk("R2", "full ph1 mag", ph1_mag_o, 180);
            chk("R2", "full ph2 mag", ph2_mag_o, 180);
        end
    endtask

    task automatic t_dir();
        do_reset();
        mode_i = 3'b011; dir_i = 1'b0;
        for (int s = 0; s < 6; s++) begin
            pulse(1);
            check_pos("R3 R10");
        end
        dir_i = 1'b1; mode_i = 3'b000;
        repeat (8) @(negedge clk);
        check_pos("R3 levels ignored between steps");
        check_dec("R3");
        pulse(1);
        check_pos("R3");
    endtask

    task automatic t_latency();
        do_reset();
        mode_i = 3'b111; dir_i = 1'b1;
        @(negedge clk);
        step_i = 1'b1;
        repeat (2) @(negedge clk);
        chk("R6", "no change after two edges", ph1_mag_o, 180);
        @(negedge clk);
        e_idx = 9;
        check_pos("R6");
        repeat (10) @(negedge clk);
        check_pos("R6 held level");
        step_i = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_sleep();
        do_reset();
        mode_i = 3'b010; dir_i = 1'b1;
        pulse(1); pulse(1);
        @(negedge clk);
        sleep_i = 1'b1;
        @(negedge clk);
        e_idx = 8; e_dec1 = 0; e_dec2 = 0;
        check_pos("R7");
        check_dec("R7");
        pulse(0);
        check_pos("R7 ignored");
        sleep_i = 1'b0;
        repeat (2) @(negedge clk);
        check_pos("R7 wake");
        pulse(1);
        check_pos("R7 resume");
    endtask

    task automatic t_enable();
        do_reset();
        mode_i = 3'b111; dir_i = 1'b1;
        enable_i = 1'b0;
        @(negedge clk);
        chk("R8", "ph1 mag off", ph1_mag_o, 0);
        chk("R8", "ph2 mag off", ph2_mag_o, 0);
        pulse(1); pulse(1);
        chk("R8", "ph1 neg off", ph1_neg_o, 0);
        chk("R8", "ph2 mag off", ph2_mag_o, 0);
        check_dec("R8");
        enable_i = 1'b1;
        @(negedge clk);
        check_pos("R8");
        repeat (9) pulse(1);
        enable_i = 1'b0;
        @(negedge clk);
        chk("R8", "ph1 neg off", ph1_neg_o, 0);
        enable_i = 1'b1;
        @(negedge clk);
        check_pos("R8 R5");
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_sweep();
        t_modes();
        t_dir();
        t_latency();
        t_sleep();
        t_enable();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule